// File: doc/BRIEF.md
# Physical Address Route Decoder

This block takes a physical address and works out which node (socket), which memory controller and which channel of that controller own it. Each node has a table of address windows, and each window has a second word that lists eight 4-bit targets. The windows form a chain: every window ends at its own limit and starts one byte above the limit of the window before it. Every entry moves this start point, including entries that are disabled.

On `start` the block first rejects addresses in the I/O hole and addresses above the top of memory. It then walks the current node's table one entry per clock. When an enabled window contains the address, the block picks a target nibble using address bits chosen by the entry. A target can send the decode once to another node, and the scan then starts again there. Otherwise the target gives a logical channel, either directly or through a modulo-3 or modulo-2 rule. The logical channel then indexes the node's route word, which yields the controller and channel numbers.

The result comes back with a one-cycle `done` pulse and a `fail` flag. Node 0 is always the node where the scan begins.

Top module: `sys_addr_router`

## Requirements
- R1: An address at or above `topHigh`, or at or above `topLow` and below 2^32, fails without any scan. `done` rises in the cycle right after the `start` cycle.
- R2: Entry bit 0 is the enable. The limit is {entry[26:7], 26 ones}. The window of entry i runs from (limit of entry i-1)+1 up to its own limit, both bounds included, with 0 as the start for entry 0. Disabled entries still move the start of the next window.
- R3: When the address lies in no enabled window of the node's 24 entries, the decode fails after all 24 entries have been examined.
- R4: Entry bits [2:1] pick the bits that form the 3-bit target index: 0 takes address[8:6], 1 takes [10:8], 2 takes [14:12] and 3 takes [32:30]. The target is the nibble of the companion word at bit position 4*index.
- R5: A target whose bit 3 is set is local. When entry bit 27 is clear, the logical channel equals target[2:0].
- R6: A target whose bit 3 is clear redirects the decode to the lowest-numbered node whose ID equals target[2:0]. The scan restarts at entry 0 of that node's table with the window start reset to 0. The reported socket is the ID of the node where the decode ends.
- R7: A second redirect target fails the decode, and so does a redirect to an ID that no node holds.
- R8: When entry bit 27 is set, bits [31:30] pick a shift of 6, 8 or 12 for the codes 0, 1 and 2. Code 3 fails the decode.
- R9: When entry bit 27 is set, let v = addr >> shift. Bits [6:5] give a base value: 0 gives v%3, 1 gives v%2, 2 gives (m<<1)|!m with m = v%2, and 3 gives (v%2)<<1. The logical channel is then (base<<1)|target[0].
- R10: The controller number is route bits [3L+2:3L] and the channel number is route bits [2L+19:2L+18], where L is the logical channel. Route bits above 31 read as 0.
- R11: `start` is accepted only while the block is idle. One entry is examined per clock. `done` is a one-cycle pulse that comes N cycles after the `start` cycle, where N counts every entry examined, including the entry that caused a redirect.
- R12: After reset, and after any failed decode, the socket, controller and channel outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode of `addr` |
| addr | input | 46 | Physical address |
| topLow | input | 46 | Top of low memory (start of the I/O hole) |
| topHigh | input | 46 | Top of memory, exclusive |
| entryTbl | input | 3072 | Window entries; entry i of node n at bits [(n*24+i)*32 +: 32] |
| targetTbl | input | 3072 | Target-list words laid out like `entryTbl` |
| nodeIds | input | 12 | 3-bit ID of each node, node n at bits [3n +: 3] |
| routeWords | input | 128 | Route word of each node, node n at bits [32n +: 32] |
| done | output | 1 | Result valid pulse |
| fail | output | 1 | Decode failed |
| socketId | output | 3 | ID of the node where the decode ended |
| mcIdx | output | 3 | Memory controller number |
| chanIdx | output | 2 | Channel number |

## Verification
Directed addresses sit on both sides of the window limits and inside the gap left by a disabled entry. These separate an off-by-one in the window start from a missed update after a disabled entry, and they also fix the full 24-cycle latency of a miss. Redirect cases cover a known node, a node ID that does not exist and a second hop, and each of these gives a different latency and socket. The four modulo rules, the illegal shift code and the all-ones local target at the top of the route word separate the channel arithmetic from the route field extraction. A pseudo-random sweep up to past the top of memory, plus a `start` pulse raised in the middle of a scan, compares the timing of `done` and every field against the reference model on every clock.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;
  localparam int NODE_W = 3;

  typedef enum logic {ST_IDLE, ST_SCAN} routeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic restart;
    logic finishOk;
    logic finishFail;
  } routeStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic rangeBad;
    logic hit;
    logic remote;
    logic remoteFound;
    logic modeBad;
  } routeStatus_t;
endpackage

// File: rtl/addr_route_ctrl.sv
module addr_route_ctrl
  import addr_route_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int NUM_NODES   = 4,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int NSEL_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int CNT_W  = $clog2(2 * NUM_ENTRIES + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  routeStatus_t      stat,
  input  logic [NSEL_W-1:0] matchNode,
  output routeStrobe_t      strobe,
  output logic [IDX_W-1:0]  entryIdx,
  output logic [NSEL_W-1:0] nodeSel,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  routeState_t state;
  logic hopped;
  logic [CNT_W-1:0] scanCnt;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        if (stat.rangeBad) strobe.finishFail = 1'b1;
        else               strobe.load = 1'b1;
      end
      ST_SCAN: begin
        if (stat.hit) begin
          if (stat.remote) begin
            if (hopped || !stat.remoteFound) strobe.finishFail = 1'b1;
            else                             strobe.restart = 1'b1;
          end else if (stat.modeBad) strobe.finishFail = 1'b1;
          else                       strobe.finishOk = 1'b1;
        end else if (entryIdx == LAST_IDX) strobe.finishFail = 1'b1;
        else                               strobe.advance = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      entryIdx <= '0;
      nodeSel  <= '0;
      hopped   <= 1'b0;
      done     <= 1'b0;
      scanCnt  <= '0;
    end else begin
      done <= strobe.finishOk | strobe.finishFail;
      if (strobe.load) begin
        state    <= ST_SCAN;
        entryIdx <= '0;
        nodeSel  <= '0;
        hopped   <= 1'b0;
        scanCnt  <= '0;
      end else if (strobe.advance) begin
        entryIdx <= entryIdx + 1'b1;
      end else if (strobe.restart) begin
        entryIdx <= '0;
        nodeSel  <= matchNode;
        hopped   <= 1'b1;
      end
      if (strobe.finishOk | strobe.finishFail) state <= ST_IDLE;
      if (state == ST_SCAN) scanCnt <= scanCnt + 1'b1;
    end
  end

  // R6: only one redirect per decode
  p_single_hop_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |-> !hopped);

  // R11: a decode never runs longer than two table walks
  p_latency_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    scanCnt <= CNT_W'(2 * NUM_ENTRIES));

  // R11: done only follows a scan or an accepted start
  p_done_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(state == ST_SCAN || start));
endmodule

// File: rtl/addr_route_dp.sv
module addr_route_dp
  import addr_route_pkg::*;
#(
  parameter int ADDR_W      = 46,
  parameter int NUM_ENTRIES = 24,
  parameter int NUM_NODES   = 4,
  localparam int TOTAL  = NUM_NODES * NUM_ENTRIES,
  localparam int FLAT_W = $clog2(TOTAL),
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int NSEL_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic [ADDR_W-1:0]           topLow,
  input  logic [ADDR_W-1:0]           topHigh,
  input  logic [TOTAL*32-1:0]         entryTbl,
  input  logic [TOTAL*32-1:0]         targetTbl,
  input  logic [NUM_NODES*NODE_W-1:0] nodeIds,
  input  logic [NUM_NODES*32-1:0]     routeWords,
  input  routeStrobe_t                strobe,
  input  logic [IDX_W-1:0]            entryIdx,
  input  logic [NSEL_W-1:0]           nodeSel,
  output routeStatus_t                stat,
  output logic [NSEL_W-1:0]           matchNode,
  output logic [NODE_W-1:0]           outSocket,
  output logic [2:0]                  outCtrl,
  output logic [1:0]                  outChan,
  output logic                        outFail
);
  localparam logic [ADDR_W-1:0] FOUR_GIB = ADDR_W'(64'd1 << 32);

  logic [31:0]       entArr   [TOTAL];
  logic [31:0]       tgtArr   [TOTAL];
  logic [NODE_W-1:0] idArr    [NUM_NODES];
  logic [31:0]       routeArr [NUM_NODES];

  for (genvar g = 0; g < TOTAL; g++) begin : g_tbl
    assign entArr[g] = entryTbl[g*32 +: 32];
    assign tgtArr[g] = targetTbl[g*32 +: 32];
  end
  for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
    assign idArr[n]    = nodeIds[n*NODE_W +: NODE_W];
    assign routeArr[n] = routeWords[n*32 +: 32];
  end

  logic [ADDR_W-1:0] addrQ, prevLimit, limitVal, shifted;
  logic [FLAT_W-1:0] flatIdx;
  logic [31:0] curEnt, curTgt;
  logic [2:0]  ilvIdx, lchan;
  logic [3:0]  tgtNib, shiftAmt;
  logic [1:0]  lchanBase;
  logic        bitM;
  logic [39:0] routeExt;

  assign flatIdx  = FLAT_W'(nodeSel) * FLAT_W'(NUM_ENTRIES) + FLAT_W'(entryIdx);
  assign curEnt   = entArr[flatIdx];
  assign curTgt   = tgtArr[flatIdx];
  assign limitVal = ADDR_W'({curEnt[26:7], {26{1'b1}}});

  always_comb begin
    unique case (curEnt[2:1])
      2'd0: ilvIdx = addrQ[8:6];
      2'd1: ilvIdx = addrQ[10:8];
      2'd2: ilvIdx = addrQ[14:12];
      default: ilvIdx = addrQ[32:30];
    endcase
  end
  assign tgtNib = curTgt[{ilvIdx, 2'b00} +: 4];

  always_comb begin
    stat.remoteFound = 1'b0;
    matchNode = '0;
    for (int n = NUM_NODES - 1; n >= 0; n--) begin
      if (idArr[n] == tgtNib[2:0]) begin
        stat.remoteFound = 1'b1;
        matchNode = NSEL_W'(n);
      end
    end
  end

  always_comb begin
    unique case (curEnt[31:30])
      2'd0: shiftAmt = 4'd6;
      2'd1: shiftAmt = 4'd8;
      default: shiftAmt = 4'd12;
    endcase
    shifted = addrQ >> shiftAmt;
    bitM = shifted[0];
    unique case (curEnt[6:5])
      2'd0: lchanBase = 2'(shifted % ADDR_W'(3));
      2'd1: lchanBase = {1'b0, bitM};
      2'd2: lchanBase = {bitM, ~bitM};
      default: lchanBase = {bitM, 1'b0};
    endcase
    lchan = curEnt[27] ? {lchanBase, tgtNib[0]} : tgtNib[2:0];
  end

  assign routeExt = {8'b0, routeArr[nodeSel]};

  assign stat.rangeBad = (addrIn >= topHigh) || (addrIn >= topLow && addrIn < FOUR_GIB);
  assign stat.hit      = curEnt[0] && addrQ >= prevLimit && addrQ <= limitVal;
  assign stat.remote   = ~tgtNib[3];
  assign stat.modeBad  = curEnt[27] && (curEnt[31:30] == 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      prevLimit <= '0;
      outSocket <= '0;
      outCtrl   <= '0;
      outChan   <= '0;
      outFail   <= 1'b0;
    end else begin
      if (strobe.load) addrQ <= addrIn;
      if (strobe.load || strobe.restart) prevLimit <= '0;
      else if (strobe.advance)           prevLimit <= limitVal + 1'b1;
      if (strobe.finishOk) begin
        outSocket <= idArr[nodeSel];
        outCtrl   <= routeExt[lchan*3 +: 3];
        outChan   <= routeExt[lchan*2 + 18 +: 2];
        outFail   <= 1'b0;
      end else if (strobe.finishFail) begin
        outSocket <= '0;
        outCtrl   <= '0;
        outChan   <= '0;
        outFail   <= 1'b1;
      end
    end
  end

  // R9: a modulo-rule channel never exceeds 5
  p_lchan_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishOk && curEnt[27]) |-> (lchan <= 3'd5));
endmodule

// File: rtl/sys_addr_router.sv
module sys_addr_router
  import addr_route_pkg::*;
#(
  parameter int ADDR_W      = 46,
  parameter int NUM_ENTRIES = 24,
  parameter int NUM_NODES   = 4,
  localparam int TOTAL  = NUM_NODES * NUM_ENTRIES,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int NSEL_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [ADDR_W-1:0]           topLow,
  input  logic [ADDR_W-1:0]           topHigh,
  input  logic [TOTAL*32-1:0]         entryTbl,
  input  logic [TOTAL*32-1:0]         targetTbl,
  input  logic [NUM_NODES*NODE_W-1:0] nodeIds,
  input  logic [NUM_NODES*32-1:0]     routeWords,
  output logic                        done,
  output logic                        fail,
  output logic [NODE_W-1:0]           socketId,
  output logic [2:0]                  mcIdx,
  output logic [1:0]                  chanIdx
);
  routeStrobe_t strobe;
  routeStatus_t stat;
  logic [NSEL_W-1:0] matchNode, nodeSel;
  logic [IDX_W-1:0]  entryIdx;

  addr_route_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_NODES(NUM_NODES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .matchNode(matchNode),
    .strobe(strobe), .entryIdx(entryIdx), .nodeSel(nodeSel), .done(done)
  );

  addr_route_dp #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .NUM_NODES(NUM_NODES)) u_dp (
    .clk(clk), .rstN(rstN), .addrIn(addr), .topLow(topLow), .topHigh(topHigh),
    .entryTbl(entryTbl), .targetTbl(targetTbl), .nodeIds(nodeIds),
    .routeWords(routeWords), .strobe(strobe), .entryIdx(entryIdx), .nodeSel(nodeSel),
    .stat(stat), .matchNode(matchNode), .outSocket(socketId), .outCtrl(mcIdx),
    .outChan(chanIdx), .outFail(fail)
  );

  // R12: a failed result carries all-zero fields
  p_fail_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> (socketId == '0 && mcIdx == '0 && chanIdx == '0));
endmodule

// File: tb/sim_sys_addr_router.sv
`timescale 1ns/1ps
module sim_sys_addr_router;
  localparam int NN = 4;
  localparam int NE = 24;
  localparam int AW = 46;
  localparam logic [63:0] TOLM = 64'hC000_0000;
  localparam logic [63:0] TOHM = 64'h2_4000_0000;
  localparam logic [63:0] G1   = 64'h4000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NN*NE*32-1:0] entFlat, tgtFlat;
  logic [NN*3-1:0] idFlat;
  logic [NN*32-1:0] routeFlat;
  logic done, fail;
  logic [2:0] socketId, mcIdx;
  logic [1:0] chanIdx;

  logic [31:0] entM [NN][NE];
  logic [31:0] tgtM [NN][NE];
  logic [2:0]  idM  [NN];
  logic [31:0] rtM  [NN];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int n = 0; n < NN; n++) begin
      idFlat[n*3 +: 3] = idM[n];
      routeFlat[n*32 +: 32] = rtM[n];
      for (int i = 0; i < NE; i++) begin
        entFlat[(n*NE+i)*32 +: 32] = entM[n][i];
        tgtFlat[(n*NE+i)*32 +: 32] = tgtM[n][i];
      end
    end
  end

  sys_addr_router u0 (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr),
    .topLow(AW'(TOLM)), .topHigh(AW'(TOHM)),
    .entryTbl(entFlat), .targetTbl(tgtFlat), .nodeIds(idFlat), .routeWords(routeFlat),
    .done(done), .fail(fail), .socketId(socketId), .mcIdx(mcIdx), .chanIdx(chanIdx)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R11 watchdog act=%0d exp<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkEnt(input int lim, input bit en, input int ilv,
                                        input bit m3, input int sh, input int sel);
    logic [19:0] l = 20'(lim);
    return {2'(sh), 2'b00, m3, l, 2'(sel), 2'b00, 2'(ilv), en};
  endfunction

  // behavioural reference: result fields and number of cycles until done
  function automatic void model(input logic [63:0] a, output bit f, output logic [2:0] s,
                                output logic [2:0] c, output logic [1:0] ch, output int n);
    int node = 0;
    bit hop = 0;
    int steps = 0;
    f = 1'b1; s = '0; c = '0; ch = '0; n = 0;
    if (a >= TOHM || (a >= TOLM && a < 64'h1_0000_0000)) return;
    for (int pass = 0; pass < 2; pass++) begin
      logic [63:0] prev = 0;
      int hitI = -1;
      logic [31:0] e;
      int idx, t, match;
      for (int i = 0; i < NE; i++) begin
        logic [63:0] lim;
        e = entM[node][i];
        lim = ({44'b0, e[26:7]} << 26) | 64'h3FF_FFFF;
        steps++;
        if (e[0] && a >= prev && a <= lim) begin hitI = i; break; end
        prev = lim + 1;
      end
      if (hitI < 0) begin n = steps; return; end
      case (e[2:1])
        2'd0: idx = int'(a[8:6]);
        2'd1: idx = int'(a[10:8]);
        2'd2: idx = int'(a[14:12]);
        default: idx = int'(a[32:30]);
      endcase
      t = int'((tgtM[node][hitI] >> (4*idx)) & 32'hF);
      if (t < 8) begin
        match = -1;
        for (int k = NN - 1; k >= 0; k--) if (int'(idM[k]) == t) match = k;
        if (hop || match < 0) begin n = steps; return; end
        node = match;
        hop = 1;
      end else begin
        int l;
        if (e[27]) begin
          int shv, lb, m;
          logic [63:0] v;
          if (e[31:30] == 2'd3) begin n = steps; return; end
          shv = (e[31:30] == 2'd0) ? 6 : (e[31:30] == 2'd1) ? 8 : 12;
          v = a >> shv;
          m = int'(v % 2);
          case (e[6:5])
            2'd0: lb = int'(v % 3);
            2'd1: lb = m;
            2'd2: lb = (m << 1) | (m == 0 ? 1 : 0);
            default: lb = m << 1;
          endcase
          l = (lb << 1) | (t & 1);
        end else begin
          l = t & 7;
        end
        begin
          logic [63:0] r = {32'b0, rtM[node]};
          c = 3'((r >> (3*l)) & 7);
          ch = 2'((r >> (2*l + 18)) & 3);
        end
        s = idM[node];
        f = 1'b0;
        n = steps;
        return;
      end
    end
  endfunction

  task automatic runOne(input logic [63:0] a, input string tag, input bit poke);
    bit ef;
    logic [2:0] es, ec;
    logic [1:0] ech;
    int en;
    model(a, ef, es, ec, ech, en);
    @(negedge clk);
    addr = AW'(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc <= en; cyc++) begin
      if (poke && cyc == 1) begin start = 1'b1; addr = AW'(TOLM); end
      if (poke && cyc == 2) start = 1'b0;
      chk(done == (cyc == en), {tag, " R11"}, "done", 64'(done), 64'(cyc == en));
      if (cyc == en) begin
        chk(fail == ef, tag, "fail", 64'(fail), 64'(ef));
        chk(socketId == es, tag, "socket", 64'(socketId), 64'(es));
        chk(mcIdx == ec, tag, "mc", 64'(mcIdx), 64'(ec));
        chk(chanIdx == ech, {tag, " R10"}, "chan", 64'(chanIdx), 64'(ech));
      end else begin
        @(negedge clk);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    logic [31:0] x;
    for (int n = 0; n < NN; n++) begin
      for (int i = 0; i < NE; i++) begin entM[n][i] = '0; tgtM[n][i] = '0; end
    end
    idM[0] = 3'd5; idM[1] = 3'd2; idM[2] = 3'd6; idM[3] = 3'd1;
    rtM[0] = 32'hA5C3_1E97; rtM[1] = 32'h6B2D_48F1; rtM[2] = 32'h1357_9BDF; rtM[3] = '0;
    // node 0
    entM[0][0] = mkEnt(15, 1, 0, 0, 0, 0);   tgtM[0][0] = 32'hFEDC_BA98;
    entM[0][1] = mkEnt(31, 0, 0, 0, 0, 0);
    entM[0][2] = mkEnt(63, 1, 1, 0, 0, 0);   tgtM[0][2] = 32'h89AB_CDEF;
    entM[0][3] = mkEnt(127, 1, 3, 0, 0, 0);  tgtM[0][3] = 32'hB762_CCCC;
    // node 1
    entM[1][0] = mkEnt(63, 0, 0, 0, 0, 0);
    entM[1][1] = mkEnt(65, 1, 0, 1, 0, 0);   tgtM[1][1] = 32'h8989_8989;
    entM[1][2] = mkEnt(67, 1, 1, 1, 1, 1);   tgtM[1][2] = 32'h9898_9898;
    entM[1][3] = mkEnt(69, 1, 2, 1, 2, 2);   tgtM[1][3] = 32'h9988_8899;
    entM[1][4] = mkEnt(71, 1, 0, 1, 0, 3);   tgtM[1][4] = 32'h8989_9898;
    entM[1][5] = mkEnt(73, 1, 0, 1, 3, 0);   tgtM[1][5] = 32'h8888_8888;
    entM[1][6] = mkEnt(79, 1, 0, 0, 0, 0);   tgtM[1][6] = 32'h2A5C_7F09;
    // node 2
    entM[2][0] = mkEnt(127, 1, 2, 0, 0, 0);  tgtM[2][0] = 32'hCDEF_89AB;

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R12", "reset done", 64'(done), 0);
    chk(fail == 1'b0 && socketId == 0 && mcIdx == 0 && chanIdx == 0, "R12",
        "reset fields", {55'b0, fail, socketId, mcIdx, chanIdx}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runOne(64'h0, "R5", 0);
    runOne(64'h1C0, "R10", 0);
    runOne(G1 - 1, "R2", 0);
    runOne(G1, "R3", 0);
    runOne(G1 + 64'h1234_5600, "R2", 0);
    runOne(2 * G1, "R2", 0);
    runOne(2 * G1 + 64'h700, "R4", 0);
    runOne(3 * G1, "R1", 0);
    runOne(4 * G1 - 1, "R1", 0);
    runOne(TOHM, "R1", 0);
    runOne(TOHM - 1, "R3", 0);
    runOne(7 * G1 + 64'h5000, "R4", 0);
    runOne(4 * G1 + 64'h1C0, "R6", 0);
    runOne(4 * G1 + 64'h0000_4440, "R9", 0);
    runOne(4 * G1 + 64'h0800_0B00, "R9", 0);
    runOne(4 * G1 + 64'h1000_7000, "R9", 0);
    runOne(4 * G1 + 64'h1800_00C0, "R9", 0);
    runOne(4 * G1 + 64'h2000_0100, "R8", 0);
    runOne(4 * G1 + 64'h2800_0040, "R7", 0);
    runOne(4 * G1 + 64'h2800_0000, "R5", 0);
    runOne(5 * G1 + 64'h3000, "R6", 0);
    runOne(6 * G1 + 64'h40, "R7", 0);
    runOne(4 * G1 + 64'h1000_2000, "R11", 1);

    x = 32'hACE1_1234;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] y;
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      y = x * 32'h9E37_79B9;
      runOne({x, y} % 64'h2_8000_0000, "R4", 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule